// File: doc/BRIEF.md
# Watchdog Timer with Protected Disable

This block is a watchdog that counts ticks from a slow timing source and raises a one-cycle reset request when the count reaches a timeout chosen by software. The tick is a clock-enable input that stands in for a dedicated oscillator, and the whole block runs on a single clock. Software controls the block through one 8-bit control register. The register holds a prescale select that chooses one of eight timeouts, an enable bit, and a turn-off enable bit that guards the enable bit against being cleared by accident.

Turning the watchdog on needs a single write. Turning it off takes two writes. The first write sets the turn-off enable bit together with the enable bit, which opens a short timed window. The second write clears the enable bit, and it only works while that window is still open. A separate restart input, used to service the watchdog, clears the counter so that a full timeout period starts again.

The timeout scale is a parameter, so a bench can use short periods. The doubling from one prescale step to the next is the same at every scale.

Top module: `wdt_guard`

## Requirements
- R1: After reset, the control register reads 0x00 and the reset request output is low.
- R2: Register bits 7 to 5 always read as zero, and writing ones to them has no effect.
- R3: Any write with bit 4 (turn-off enable) set makes bit 4 read as one. From the fourth rising edge after that write, bit 4 reads as zero again without any further write.
- R4: A write with bit 3 (enable) set enables the watchdog at that write's edge, with no protection step, and bit 3 then reads as one.
- R5: A write with bit 3 clear disables the watchdog only if bit 4 already read as one before that write's edge. In every other case bit 3 stays one.
- R6: Writing 0x18 and then, at any of the next four edges, a value with bit 3 clear disables the watchdog. The same second write made at the fifth edge or later leaves it enabled.
- R7: A write with bit 4 set made while the window is open restarts the four-edge window.
- R8: Bits 2 to 0 hold the prescale select s, which is written on every write. While enabled, the timeout is 2^(BASE_LOG2+s) ticks, so the default BASE_LOG2 of 13 gives 8K to 1024K ticks.
- R9: A pulse on the restart input clears the counter. The next reset request comes a full period after the restart edge.
- R10: The counter moves only on an edge where tick is high and the watchdog is enabled. While disabled, the counter holds at zero, so no request is raised and the first period after enabling is a full one.
- R11: At timeout, the reset request is high for exactly one cycle and the counter wraps to zero, so requests repeat once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the register and the counter |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Data written to the control register |
| rdData | output | 8 | Current value of the control register |
| restart | input | 1 | Clears the watchdog counter |
| tick | input | 1 | One-cycle enable for each watchdog oscillator period |
| resetReq | output | 1 | One-cycle reset request at timeout |

## Verification
The counting path is run with a continuous tick at the smallest and the largest prescale. This tells a correct tap choice and wrap-around apart from an off-by-one terminal count. A sparse tick pattern, one tick every third cycle, shows whether the counter follows the tick or the clock. A restart placed in the middle of a period separates a real counter clear from a request that only looks late. The register protocol is tried with an unguarded clear, a second write on the last edge inside the window, a second write one edge too late, and a window that is reopened. Together these pin down the exact length and restart behaviour of the protection window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_TAPS = 1 << SEL_W;
  localparam int unsigned RSVD_W   = 3;

  // Reserved bits keep nothing that is written to them.
  localparam logic [RSVD_W-1:0] RSVD_KEEP = '0;

  // Field layout of the control register, MSB first.
  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic              toe;
    logic              en;
    logic [SEL_W-1:0]  sel;
  } ctlReg_t;

  // Strobes that the control half sends to the counter half.
  typedef struct packed {
    logic clear;
    logic step;
  } cntStrobe_t;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             restart,
  input  logic             tick,
  output logic [SEL_W-1:0] sel,
  output logic [7:0]       rdData,
  output cntStrobe_t       strobe
);

  localparam int unsigned WIN_W = $clog2(WIN_CYC + 1);

  ctlReg_t          ctlQ;
  ctlReg_t          wrImg;
  logic [WIN_W-1:0] winQ;
  logic             openWin;

  assign wrImg   = ctlReg_t'(wrData);
  assign openWin = wrEn && wrImg.toe;

  // Enable, prescale select and reserved bits.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ.rsvd <= '0;
      ctlQ.en   <= 1'b0;
      ctlQ.sel  <= '0;
    end else if (wrEn) begin
      ctlQ.rsvd <= wrImg.rsvd & RSVD_KEEP;
      ctlQ.sel  <= wrImg.sel;
      if (wrImg.en) begin
        ctlQ.en <= 1'b1;
      end else if (ctlQ.toe) begin
        ctlQ.en <= 1'b0;
      end
    end
  end

  // Turn-off enable and its self-clearing window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ.toe <= 1'b0;
      winQ     <= '0;
    end else if (openWin) begin
      ctlQ.toe <= 1'b1;
      winQ     <= WIN_W'(WIN_CYC);
    end else if (ctlQ.toe) begin
      if (winQ <= WIN_W'(1)) begin
        ctlQ.toe <= 1'b0;
        winQ     <= '0;
      end else begin
        winQ <= winQ - WIN_W'(1);
      end
    end
  end

  assign sel          = ctlQ.sel;
  assign rdData       = 8'(ctlQ);
  assign strobe.clear = !ctlQ.en || restart;
  assign strobe.step  = ctlQ.en && tick;

endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [SEL_W-1:0] sel,
  output logic             resetReq
);

  localparam int unsigned CNT_W = BASE_LOG2 + NUM_TAPS - 1;

  logic [CNT_W-1:0] taps [NUM_TAPS];
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] term;
  logic             atTerm;
  logic             reqQ;

  // One terminal value per prescale step, each twice the previous period.
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign taps[g] = CNT_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
  end

  assign term   = taps[sel];
  assign atTerm = (cntQ >= term);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      reqQ <= 1'b0;
    end else if (strobe.clear) begin
      cntQ <= '0;
      reqQ <= 1'b0;
    end else if (strobe.step) begin
      if (atTerm) begin
        cntQ <= '0;
        reqQ <= 1'b1;
      end else begin
        cntQ <= cntQ + CNT_W'(1);
        reqQ <= 1'b0;
      end
    end else begin
      reqQ <= 1'b0;
    end
  end

  assign resetReq = reqQ;

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 13,
  parameter int unsigned WIN_CYC   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       restart,
  input  logic       tick,
  output logic       resetReq
);

  cntStrobe_t       strobe;
  logic [SEL_W-1:0] sel;

  wdt_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .restart (restart),
    .tick    (tick),
    .sel     (sel),
    .rdData  (rdData),
    .strobe  (strobe)
  );

  wdt_count #(.BASE_LOG2(BASE_LOG2)) u_count (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sel      (sel),
    .resetReq (resetReq)
  );

endmodule

// File: rtl/wdt_guard_checker.sv
module wdt_guard_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       restart,
  input logic       tick,
  input logic       resetReq
);

  p_toe_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[4]) |-> $past(wrEn && wrData[4]));

  p_enable_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[3]) |=> rdData[3]);

  p_guarded_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdData[3]) |-> $past(wrEn && !wrData[3] && rdData[4]));

  p_restart_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !$past(restart));

  p_needs_enable_r10: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(rdData[3]));

  p_needs_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(tick));

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

endmodule

bind wdt_guard wdt_guard_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdData   (rdData),
  .restart  (restart),
  .tick     (tick),
  .resetReq (resetReq)
);

// File: tb/wdt_guard_test.sv
module wdt_guard_test;

  localparam int BASE = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       restart = 1'b0;
  logic       tick = 1'b0;
  logic       resetReq;

  int checks = 0;
  int fails = 0;
  int edgeCnt = 0;
  int expQ[$];
  bit done = 1'b0;

  wdt_guard #(.BASE_LOG2(BASE), .WIN_CYC(4)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .restart(restart), .tick(tick), .resetReq(resetReq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  // Monitor: every request must match the oldest expected edge.
  always @(negedge clk) begin
    if (rstN && resetReq) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R10/R11: unexpected reset request at edge %0d (expected none)", edgeCnt);
      end else begin
        int e;
        e = expQ.pop_front();
        if (e != edgeCnt) begin
          fails++;
          $display("FAIL R8/R9/R11: request at edge %0d, expected %0d", edgeCnt, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] d, output int edgeNo);
    wrEn = 1'b1; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
    edgeNo = edgeCnt;
  endtask

  task automatic pulseRestart(output int edgeNo);
    restart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0;
    edgeNo = edgeCnt;
  endtask

  task automatic checkRd(input logic [7:0] exp, input string req);
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s: rdData=%02h expected %02h", req, rdData, exp);
    end
  endtask

  task automatic checkDrained(input string req);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d requests missing, expected 0", req, expQ.size());
      expQ.delete();
    end
  endtask

  task automatic shutDown();
    int w;
    tick = 1'b0;
    writeReg(8'h18, w);
    writeReg(8'h00, w);
  endtask

  initial begin
    int w;
    int r;
    idle(3);
    rstN = 1'b1;
    checkRd(8'h00, "R1");
    checks++;
    if (resetReq !== 1'b0) begin
      fails++;
      $display("FAIL R1: resetReq=%b expected 0", resetReq);
    end

    // R2: reserved bits
    writeReg(8'hE5, w); checkRd(8'h05, "R2");
    writeReg(8'hE0, w); checkRd(8'h00, "R2");

    // R4 enable, R5 unguarded clear ignored
    writeReg(8'h08, w); checkRd(8'h08, "R4");
    writeReg(8'h00, w); checkRd(8'h08, "R5");

    // R6: second write on the fourth edge succeeds
    writeReg(8'h18, w); checkRd(8'h18, "R3");
    idle(3);            checkRd(8'h18, "R3");
    writeReg(8'h00, w); checkRd(8'h00, "R6");

    // R3 self-clear, R6 late write fails
    writeReg(8'h08, w);
    writeReg(8'h18, w);
    idle(3);            checkRd(8'h18, "R3");
    idle(1);            checkRd(8'h08, "R3");
    writeReg(8'h00, w); checkRd(8'h08, "R6");

    // R7: reopened window
    writeReg(8'h18, w);
    idle(2);
    writeReg(8'h18, w);
    idle(3);
    writeReg(8'h00, w); checkRd(8'h00, "R7");

    // R10: disabled with ticks gives no request
    tick = 1'b1;
    idle(40);

    // R4/R8/R11: smallest prescale, two periods
    writeReg(8'h08, w);
    expQ.push_back(w + 8);
    expQ.push_back(w + 16);
    idle(18);
    shutDown();
    checkDrained("R11");

    // R9: restart mid-period, prescale 3
    tick = 1'b1;
    writeReg(8'h0B, w);
    idle(40);
    pulseRestart(r);
    expQ.push_back(r + 64);
    idle(70);
    shutDown();
    checkDrained("R9");

    // R8: largest prescale
    tick = 1'b1;
    writeReg(8'h0F, w);
    expQ.push_back(w + 1024);
    idle(1030);
    shutDown();
    checkDrained("R8");

    // R10: sparse ticks, prescale 1
    writeReg(8'h09, w);
    for (int i = 0; i < 16; i++) begin
      if (i == 15) expQ.push_back(edgeCnt + 1);
      tick = 1'b1;
      idle(1);
      tick = 1'b0;
      idle(2);
    end
    idle(3);
    shutDown();
    checkDrained("R10");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule